// File: doc/BRIEF.md
# Digit-Serial Twin Constant Multiplier (29x and 43x)

This block multiplies one unsigned input word by the two fixed constants 29 and 43 at the same time. The word arrives as a stream of digits, `D` bits per accepted cycle, least significant digit first. Both products leave on two `D`-bit output lanes in the same digit order. The arithmetic is a fixed shift-and-add network that works one digit at a time. A shared term `7x = 8x - x` comes from one digit-serial subtractor. Two digit-serial adders then form `29x = 4·7x + x` and `43x = 29x + 2·7x`. Every left shift is a short flip-flop chain, not free wiring. The two multiples of 7x come from one chain: its first stage supplies the shift by one and its end supplies the shift by two.

A frame is `NDIG = ceil((W+6)/D)` digits long. That is wide enough for the full 43x product of a `W`-bit input. The sender drives the zero-extended word across all `NDIG` digits and raises `in_sow` with the first digit. That strobe reinitialises every carry and shift stage, so frames can follow each other back to back. A frame that is cut short is simply dropped. Cycles with `in_valid` low are bubbles that freeze the whole datapath.

Top module: `dsm_twin_const_mul`

## Requirements
- R1: Over a frame of `NDIG` accepted digits, the bits collected from `out_p29` equal 29·x. Bit `i` of output digit `k` carries product bit `k*D+i`, and x is driven the same way on `in_digit`, with the digits above bit `W-1` set to zero.
- R2: Over the same frame, the bits collected from `out_p43` equal 43·x, using the same bit placement as R1.
- R3: Each accepted input digit yields its output digit on the next clock. `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high.
- R4: `out_last` is high only together with `out_valid`. It is high with the output digit of the input digit that lies `NDIG-1` accepted digits after the `in_sow` digit, so one frame carries exactly `NDIG` output digits.
- R5: An accepted digit with `in_sow` high starts a new frame whose results do not depend on any earlier digits. This holds even when the earlier frame was abandoned before its last digit.
- R6: A cycle with `in_valid` low changes no carry, shift or digit-count state. In the next cycle `out_valid` and `out_last` are low and both output digit lanes keep their previous values.
- R7: While `rst` is high, all outputs are driven to zero in the cycle after the clock edge.
- R8: The all-ones W-bit input gives the complete 43x product without truncation (10965 for W = 8).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input digit present this cycle |
| in_sow | input | 1 | Marks the least significant digit of a new word |
| in_digit | input | D | Input digit, LSB at bit 0 |
| out_valid | output | 1 | Output digits present this cycle |
| out_last | output | 1 | Final digit of the product frame |
| out_p29 | output | D | Digit of 29·x |
| out_p43 | output | D | Digit of 43·x |

## Verification
The embedded assertions check the cycle-level rules on every clock: `out_valid` tracks `in_valid` one clock later, bubbles freeze the output lanes, `out_last` never appears without `out_valid`, and a start digit always fills its shift stages with zeros. A zero start digit must also give zero output digits whatever came before. Whether the collected frames form the right products can only be shown by the bench. It sweeps every 8-bit input at digit sizes 1, 2 and 4, with bubbles and abandoned frames mixed in, and compares the reassembled frames against 29·x and 43·x computed arithmetically.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

    // Extra product bits needed by the larger constant (43 < 2^6)
    localparam int DSM_GROWTH = 6;

    typedef enum logic {
        DSM_OP_ADD = 1'b0,
        DSM_OP_SUB = 1'b1
    } dsm_op_e;

    function automatic int frame_digits(input int bits, input int dsz);
        return (bits + dsz - 1) / dsz;
    endfunction

endpackage

// File: rtl/dsm_serial_addsub.sv
module dsm_serial_addsub
    import dsm_pkg::*;
#(
    parameter int      D  = 2,
    parameter dsm_op_e OP = DSM_OP_ADD
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         sow,
    input  logic [D-1:0] a,
    input  logic [D-1:0] b,
    output logic [D-1:0] s
);

    localparam logic CARRY_INIT = (OP == DSM_OP_SUB);

    logic [D-1:0] b_eff;
    logic [D:0]   cy;
    logic         carry_q;

    generate
        if (OP == DSM_OP_SUB) begin : g_inv
            assign b_eff = ~b;
        end else begin : g_pass
            assign b_eff = b;
        end
    endgenerate

    assign cy[0] = sow ? CARRY_INIT : carry_q;

    generate
        for (genvar i = 0; i < D; i++) begin : g_fa
            assign s[i]    = a[i] ^ b_eff[i] ^ cy[i];
            assign cy[i+1] = (a[i] & b_eff[i]) | (cy[i] & (a[i] ^ b_eff[i]));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            carry_q <= CARRY_INIT;
        end else if (en) begin
            carry_q <= cy[D];
        end
    end

    // R5: a fresh word with zero operands yields a zero digit for both add and subtract
    a_r5_clean_digit: assert property (@(posedge clk) disable iff (rst)
        (en && sow && a == '0 && b == '0) |-> (s == '0));

endmodule

// File: rtl/dsm_shift_chain.sv
module dsm_shift_chain #(
    parameter int D   = 2,
    parameter int LS  = 2,
    parameter int TAP = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         sow,
    input  logic [D-1:0] din,
    output logic [D-1:0] dout,
    output logic [D-1:0] dtap
);

    localparam int ZB = (LS < D) ? LS : D;

    logic [LS-1:0]   hist_q;
    logic [LS-1:0]   hist_eff;
    logic [D+LS-1:0] joined;

    // Zeros enter below the LSB at the start of every word
    assign hist_eff = sow ? '0 : hist_q;
    assign joined   = {din, hist_eff};
    assign dout     = joined[D-1:0];

    generate
        if (TAP > 0) begin : g_tap
            logic [D+TAP-1:0] joined_tap;
            assign joined_tap = {din, hist_eff[LS-1 -: TAP]};
            assign dtap       = joined_tap[D-1:0];
        end else begin : g_notap
            assign dtap = din;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else if (en) begin
            hist_q <= joined[D+LS-1:D];
        end
    end

    // R5: the lowest shifted positions of a new word are zero-filled
    a_r5_zero_fill: assert property (@(posedge clk) disable iff (rst)
        (en && sow) |-> (dout[ZB-1:0] == '0));

endmodule

// File: rtl/dsm_frame_ctl.sv
module dsm_frame_ctl #(
    parameter int NDIG = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic sow,
    output logic last
);

    localparam int CW = $clog2(NDIG + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] pos;

    assign pos  = sow ? '0 : cnt_q;
    assign last = en && (pos == CW'(NDIG - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= pos + CW'(1);
        end
    end

    // R4: a start digit is the final digit only for a single-digit frame
    a_r4_sow_not_last: assert property (@(posedge clk) disable iff (rst)
        (en && sow && NDIG > 1) |-> !last);

endmodule

// File: rtl/dsm_twin_const_mul.sv
module dsm_twin_const_mul
    import dsm_pkg::*;
#(
    parameter int W = 8,
    parameter int D = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic         in_sow,
    input  logic [D-1:0] in_digit,
    output logic         out_valid,
    output logic         out_last,
    output logic [D-1:0] out_p29,
    output logic [D-1:0] out_p43
);

    localparam int FW   = W + DSM_GROWTH;
    localparam int NDIG = frame_digits(FW, D);

    typedef struct packed {
        logic         valid;
        logic         last;
        logic [D-1:0] p29;
        logic [D-1:0] p43;
    } out_digit_t;

    logic [D-1:0] x_sh3;
    logic [D-1:0] x_unused_tap;
    logic [D-1:0] t7;
    logic [D-1:0] t7_sh2;
    logic [D-1:0] t7_sh1;
    logic [D-1:0] p29_c;
    logic [D-1:0] p43_c;
    logic         last_c;
    out_digit_t   o_q;

    // 8x
    dsm_shift_chain #(.D(D), .LS(3), .TAP(0)) u_sh_x3 (
        .clk(clk), .rst(rst), .en(in_valid), .sow(in_sow),
        .din(in_digit), .dout(x_sh3), .dtap(x_unused_tap)
    );

    // 7x = 8x - x
    dsm_serial_addsub #(.D(D), .OP(DSM_OP_SUB)) u_sub7 (
        .clk(clk), .rst(rst), .en(in_valid), .sow(in_sow),
        .a(x_sh3), .b(in_digit), .s(t7)
    );

    // 28x at the chain end, 14x from its first stage
    dsm_shift_chain #(.D(D), .LS(2), .TAP(1)) u_sh_t7 (
        .clk(clk), .rst(rst), .en(in_valid), .sow(in_sow),
        .din(t7), .dout(t7_sh2), .dtap(t7_sh1)
    );

    // 29x = 28x + x
    dsm_serial_addsub #(.D(D), .OP(DSM_OP_ADD)) u_add29 (
        .clk(clk), .rst(rst), .en(in_valid), .sow(in_sow),
        .a(t7_sh2), .b(in_digit), .s(p29_c)
    );

    // 43x = 29x + 14x
    dsm_serial_addsub #(.D(D), .OP(DSM_OP_ADD)) u_add43 (
        .clk(clk), .rst(rst), .en(in_valid), .sow(in_sow),
        .a(p29_c), .b(t7_sh1), .s(p43_c)
    );

    dsm_frame_ctl #(.NDIG(NDIG)) u_frame (
        .clk(clk), .rst(rst), .en(in_valid), .sow(in_sow), .last(last_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            o_q <= '0;
        end else begin
            o_q.valid <= in_valid;
            o_q.last  <= last_c;
            if (in_valid) begin
                o_q.p29 <= p29_c;
                o_q.p43 <= p43_c;
            end
        end
    end

    assign out_valid = o_q.valid;
    assign out_last  = o_q.last;
    assign out_p29   = o_q.p29;
    assign out_p43   = o_q.p43;

    // R3: every accepted digit produces an output digit one clock later
    a_r3_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R6: a bubble freezes the output lanes and drops the flags
    a_r6_bubble_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_last && $stable(out_p29) && $stable(out_p43)));

    // R4: the frame end flag only rides on a valid digit
    a_r4_last_valid: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    // R5: a zero start digit gives zero product digits regardless of history
    a_r5_start_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sow && in_digit == '0) |=> (out_p29 == '0 && out_p43 == '0));

endmodule

// File: tb/dsm_twin_const_mul_tb.sv
module dsm_twin_const_mul_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TB_W       = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    int   checks   = 0;
    int   failures = 0;
    bit   finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int dg,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s D=%0d actual=%0d expected=%0d", req, dg, act, exp);
        end
    endtask

    for (genvar gi = 0; gi < 3; gi++) begin : g_dig
        localparam int DG   = 1 << gi;
        localparam int NDG  = (TB_W + 6 + DG - 1) / DG;

        logic          in_valid = 1'b0;
        logic          in_sow   = 1'b0;
        logic [DG-1:0] in_digit = '0;
        logic          out_valid;
        logic          out_last;
        logic [DG-1:0] out_p29;
        logic [DG-1:0] out_p43;
        logic          vld_q = 1'b0;
        logic          sow_q = 1'b0;
        bit            blk_done = 1'b0;
        bit            mon_on   = 1'b0;
        int            pending[$];
        int            oidx = 0;
        logic [31:0]   acc29 = '0;
        logic [31:0]   acc43 = '0;
        logic [DG-1:0] prev29 = '0;
        logic [DG-1:0] prev43 = '0;

        dsm_twin_const_mul #(.W(TB_W), .D(DG)) u_dut (
            .clk(clk), .rst(rst), .in_valid(in_valid), .in_sow(in_sow),
            .in_digit(in_digit), .out_valid(out_valid), .out_last(out_last),
            .out_p29(out_p29), .out_p43(out_p43)
        );

        // bench-side model of the one-clock digit latency (R3)
        always @(posedge clk) begin
            vld_q <= rst ? 1'b0 : in_valid;
            sow_q <= rst ? 1'b0 : (in_valid & in_sow);
        end

        task automatic put(input bit v, input bit s, input logic [DG-1:0] d);
            @(posedge clk);
            #1;
            in_valid = v;
            in_sow   = s;
            in_digit = d;
        endtask

        always @(negedge clk) begin
            if (mon_on && !rst) begin
                check(out_valid === vld_q, "R3", DG, out_valid, vld_q);
                if (out_valid) begin
                    if (sow_q) begin
                        oidx  = 0;
                        acc29 = '0;
                        acc43 = '0;
                    end
                    acc29[oidx*DG +: DG] = out_p29;
                    acc43[oidx*DG +: DG] = out_p43;
                    oidx++;
                    if (out_last) begin
                        int x;
                        x = (pending.size() > 0) ? pending.pop_front() : -1;
                        check(oidx == NDG, "R4", DG, oidx, NDG);
                        check(acc29 == 32'(29 * x), "R1", DG, acc29, 29 * x);
                        check(acc43 == 32'(43 * x), "R2", DG, acc43, 43 * x);
                        if (x == (1 << TB_W) - 1)
                            check(acc43 == 32'd10965, "R8", DG, acc43, 10965);
                    end
                end else begin
                    check(!out_last && out_p29 == prev29 && out_p43 == prev43,
                          "R6", DG, {out_last, out_p29, out_p43}, {1'b0, prev29, prev43});
                end
                prev29 = out_p29;
                prev43 = out_p43;
            end
        end

        initial begin
            repeat (2) @(posedge clk);
            @(negedge clk);
            check(out_valid == 1'b0 && out_last == 1'b0 && out_p29 == '0 && out_p43 == '0,
                  "R7", DG, {out_valid, out_last, out_p29, out_p43}, 0);
            while (rst) @(posedge clk);
            mon_on = 1'b1;
            for (int x = 0; x < (1 << TB_W); x++) begin
                logic [31:0] xe;
                xe = 32'(x);
                if (x % 64 == 17) begin
                    // R5: abandoned frame of all-ones digits before the real word
                    put(1'b1, 1'b1, '1);
                    put(1'b1, 1'b0, '1);
                end
                pending.push_back(x);
                for (int k = 0; k < NDG; k++) begin
                    if (k == 1 && x % 7 == 3) put(1'b0, 1'b0, '1); // R6 bubble
                    put(1'b1, k == 0, xe[k*DG +: DG]);
                end
            end
            repeat (4) put(1'b0, 1'b0, '0);
            check(pending.size() == 0, "R4", DG, pending.size(), 0);
            blk_done = 1'b1;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        while (!(g_dig[0].blk_done && g_dig[1].blk_done && g_dig[2].blk_done))
            @(posedge clk);
        repeat (2) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule